// File: doc/BRIEF.md
# DMA Transfer Request Queue

This block is the register-facing front end of a single-channel DMA engine. Software programs a destination address, a source address, a length and a repeat flag into staging registers, then writes a submit register. The block gives each accepted request a rolling 5-bit tag and places it in a short queue. The queue offers requests one at a time to the data-moving datapath, which takes each one with a request/acknowledge handshake.

When the datapath finishes a transfer it pulses a done strobe that carries the tag. The block records this in a 32-bit completion bitmap and raises an end-of-transfer interrupt. Taking a request out of the queue raises a start-of-transfer interrupt, which tells software that queue space has become free. Software can read the tag the next submit will receive, the tag of the transfer in progress, and a busy indication on the submit register that acts as queue backpressure. A request marked as repeating stays at the head of the queue and is offered again after every acknowledge, until the channel is disabled.

Top module: `dma_req_frontend`

## Requirements
- R1: After reset the interrupt mask (0x080) reads 3, and the following all read 0: interrupt pending (0x084), control (0x400), next tag (0x404), submit (0x408), completion bitmap (0x428) and active tag (0x42c). `irq` and `req_valid` are low.
- R2: Writing a value with bit 0 set to 0x408 while the channel is enabled marks a submission as pending. The submission enters the queue at the first clock edge where the queue is not full. At that edge the request takes the tag then shown at 0x404, and 0x404 increases by one. Writes to the staging registers (0x40c flags, 0x410 destination, 0x414 source, 0x418 length) are ignored while a submission is pending.
- R3: Reading 0x408 returns 1 while a submission is pending or the queue holds QUEUE_DEPTH entries. Otherwise it returns 0. A submit write made while a submission is already pending is ignored.
- R4: Requests are offered on `req_*` in submission order. The payload holds steady while `req_valid` is high and `req_ack` is low. An acknowledged request that is not repeating leaves the queue and sets pending bit 0 (start-of-transfer) at the same edge.
- R5: A `done_strobe` sets bit `done_id` of 0x428 and pending bit 1 (end-of-transfer) at the edge that samples it. A bitmap bit is cleared at the edge where its tag is given to a new submission.
- R6: Writing ones to 0x084 clears those pending bits. If a clear and a new event for the same bit fall on the same edge, the bit stays set.
- R7: A mask bit (0x080, bit 0 = start, bit 1 = end) of 1 hides that source. 0x088 reads pending AND NOT mask, and `irq` is high exactly when 0x088 is nonzero. Writing 0 to the mask enables both sources.
- R8: Control bit 1 (pause), with bit 0 (enable) set, holds `req_valid` low. Submissions are still accepted into the queue. Clearing the pause resumes hand-off.
- R9: Writing control with bit 0 clear empties the queue and cancels a pending submission. 0x404 does not change. While the channel is disabled, submit writes are ignored and `req_valid` stays low.
- R10: A request submitted with flags bit 0 set is repeating. Each acknowledge of it leaves it at the head, offered again with the same tag, and does not set the start-of-transfer bit.
- R11: 0x42c holds the tag of the most recently acknowledged request.
- R12: Tags run from 0 to 31. The tag after 31 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| req_valid | output | 1 | Request offered to the datapath |
| req_id | output | 5 | Tag of the offered request |
| req_cyclic | output | 1 | Offered request repeats |
| req_dst | output | 32 | Destination address |
| req_src | output | 32 | Source address |
| req_len | output | 24 | Transfer length |
| req_ack | input | 1 | Datapath takes the offered request |
| done_strobe | input | 1 | One-cycle transfer completion pulse |
| done_id | input | 5 | Tag of the completed transfer |
| irq | output | 1 | Interrupt request |

## Verification
Register reads are combinational, so a read returns the state left by the most recent clock edge. A register write takes effect at the edge that samples it. A submission reaches the queue, and 0x404 steps, one edge after the submit write when the queue has room. The start-of-transfer bit, the end-of-transfer bit, the bitmap and the active tag all change at the same edge as the acknowledge or done strobe that causes them. The bench drives every input on the falling edge and reads 1 ns later, so each check sees the state after the rising edge that was supposed to cause it. A scoreboard queue holds the expected request stream. A monitor compares each acknowledged request against the queue head at the falling edge before the acknowledge edge.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int ID_W    = 5;
  localparam int NUM_IDS = 1 << ID_W;
  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 24;
  localparam int DATA_W  = 32;

  // register byte offsets
  localparam logic [11:0] OFS_IRQ_MASK = 12'h080;
  localparam logic [11:0] OFS_IRQ_PEND = 12'h084;
  localparam logic [11:0] OFS_IRQ_SRC  = 12'h088;
  localparam logic [11:0] OFS_CTRL     = 12'h400;
  localparam logic [11:0] OFS_NEXT_ID  = 12'h404;
  localparam logic [11:0] OFS_SUBMIT   = 12'h408;
  localparam logic [11:0] OFS_FLAGS    = 12'h40c;
  localparam logic [11:0] OFS_DST      = 12'h410;
  localparam logic [11:0] OFS_SRC      = 12'h414;
  localparam logic [11:0] OFS_LEN      = 12'h418;
  localparam logic [11:0] OFS_DONE     = 12'h428;
  localparam logic [11:0] OFS_ACTIVE   = 12'h42c;

  localparam int IRQ_START = 0;
  localparam int IRQ_END   = 1;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              cyclic;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
    logic [LEN_W-1:0]  len;
  } xfer_req_t;

  function automatic logic [ID_W-1:0] id_after(input logic [ID_W-1:0] id);
    return id + ID_W'(1);
  endfunction

  function automatic logic [NUM_IDS-1:0] id_onehot(input logic [ID_W-1:0] id);
    return NUM_IDS'(1) << id;
  endfunction

  function automatic logic [1:0] irq_visible(input logic [1:0] pend,
                                             input logic [1:0] mask);
    return pend & ~mask;
  endfunction
endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo
  import dmaq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  xfer_req_t push_data,
  input  logic      pop,
  input  logic      flush,
  output xfer_req_t head,
  output logic      valid,
  output logic      full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  xfer_req_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign valid   = (count != '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign push_ok = push && !flush && !full;
  assign pop_ok  = pop && !flush && valid;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_step(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R3: the front end never pushes into a full queue
  a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> !full);
  // R4: a pop only happens with an entry present
  a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> valid);
endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq
  import dmaq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_evt,
  input  logic       end_evt,
  input  logic       mask_we,
  input  logic [1:0] mask_wdata,
  input  logic       clr_we,
  input  logic [1:0] clr_bits,
  output logic [1:0] pend,
  output logic [1:0] mask,
  output logic [1:0] src,
  output logic       irq
);
  logic [1:0] set_bits, clr_mask, pend_n;

  always_comb begin
    set_bits            = '0;
    set_bits[IRQ_START] = start_evt;
    set_bits[IRQ_END]   = end_evt;
    clr_mask            = clr_we ? clr_bits : 2'b00;
    pend_n              = (pend & ~clr_mask) | set_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= 2'b11;
    end else begin
      pend <= pend_n;
      if (mask_we) mask <= mask_wdata;
    end
  end

  assign src = irq_visible(pend, mask);
  assign irq = |src;

  // R6: an event beats a simultaneous clear
  a_r6_end_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> pend[IRQ_END]);
  // R6: a clear without an event drops the bit
  a_r6_start_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits[IRQ_START] && !start_evt) |=> !pend[IRQ_START]);
endmodule

// File: rtl/dmaq_idtrack.sv
module dmaq_idtrack
  import dmaq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc,
  input  logic               start_evt,
  input  logic [ID_W-1:0]    start_id,
  input  logic               done_strobe,
  input  logic [ID_W-1:0]    done_id,
  output logic [ID_W-1:0]    next_id,
  output logic [NUM_IDS-1:0] done_map,
  output logic [ID_W-1:0]    active_id
);
  logic [NUM_IDS-1:0] set_mask, clr_mask, done_map_n;

  always_comb begin
    set_mask   = done_strobe ? id_onehot(done_id) : '0;
    clr_mask   = alloc ? id_onehot(next_id) : '0;
    done_map_n = (done_map & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_id   <= '0;
      done_map  <= '0;
      active_id <= '0;
    end else begin
      done_map <= done_map_n;
      if (alloc)     next_id   <= id_after(next_id);
      if (start_evt) active_id <= start_id;
    end
  end

  // R5: a completion is recorded at the sampling edge
  a_r5_done_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    done_strobe |=> done_map[$past(done_id)]);
  // R5: handing out a tag clears its completion bit
  a_r5_reuse_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !(done_strobe && done_id == next_id)) |=> !done_map[$past(next_id)]);
  // R12: tag 31 is followed by tag 0
  a_r12_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && next_id == ID_W'(NUM_IDS - 1)) |=> (next_id == '0));
endmodule

// File: rtl/dma_req_frontend.sv
module dma_req_frontend
  import dmaq_pkg::*;
#(
  parameter int QUEUE_DEPTH = 4,
  parameter int REG_AW      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              req_valid,
  output logic [ID_W-1:0]   req_id,
  output logic              req_cyclic,
  output logic [ADDR_W-1:0] req_dst,
  output logic [ADDR_W-1:0] req_src,
  output logic [LEN_W-1:0]  req_len,
  input  logic              req_ack,
  input  logic              done_strobe,
  input  logic [ID_W-1:0]   done_id,
  output logic              irq
);
  // control and staging state
  logic              ctrl_en, ctrl_pause, stg_cyc, sub_pend;
  logic [ADDR_W-1:0] stg_dst, stg_src;
  logic [LEN_W-1:0]  stg_len;

  // named events
  logic wr_ctrl, wr_submit, wr_mask, wr_pend, stage_open;
  logic disable_evt, submit_evt, push_evt, handoff_evt, pop_evt;
  logic busy;

  // sub-block outputs
  xfer_req_t          q_head, q_in;
  logic               q_valid, q_full;
  logic [1:0]         irq_pend, irq_mask, irq_src;
  logic [ID_W-1:0]    next_id, active_id;
  logic [NUM_IDS-1:0] done_map;

  assign wr_ctrl     = reg_wr && (reg_addr == REG_AW'(OFS_CTRL));
  assign wr_submit   = reg_wr && (reg_addr == REG_AW'(OFS_SUBMIT));
  assign wr_mask     = reg_wr && (reg_addr == REG_AW'(OFS_IRQ_MASK));
  assign wr_pend     = reg_wr && (reg_addr == REG_AW'(OFS_IRQ_PEND));
  assign stage_open  = reg_wr && !sub_pend;

  assign disable_evt = wr_ctrl && !reg_wdata[0];
  assign submit_evt  = wr_submit && reg_wdata[0] && ctrl_en && !sub_pend;
  assign push_evt    = sub_pend && ctrl_en && !q_full && !disable_evt;
  assign req_valid   = q_valid && ctrl_en && !ctrl_pause;
  assign handoff_evt = req_valid && req_ack;
  assign pop_evt     = handoff_evt && !q_head.cyclic;
  assign busy        = sub_pend || q_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      ctrl_pause <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_en    <= reg_wdata[0];
      ctrl_pause <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_cyc <= 1'b0;
      stg_dst <= '0;
      stg_src <= '0;
      stg_len <= '0;
    end else if (stage_open) begin
      if (reg_addr == REG_AW'(OFS_FLAGS)) stg_cyc <= reg_wdata[0];
      if (reg_addr == REG_AW'(OFS_DST))   stg_dst <= reg_wdata;
      if (reg_addr == REG_AW'(OFS_SRC))   stg_src <= reg_wdata;
      if (reg_addr == REG_AW'(OFS_LEN))   stg_len <= reg_wdata[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || disable_evt) sub_pend <= 1'b0;
    else if (submit_evt)       sub_pend <= 1'b1;
    else if (push_evt)         sub_pend <= 1'b0;
  end

  always_comb begin
    q_in.id     = next_id;
    q_in.cyclic = stg_cyc;
    q_in.dst    = stg_dst;
    q_in.src    = stg_src;
    q_in.len    = stg_len;
  end

  dmaq_fifo #(.DEPTH(QUEUE_DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_evt),
    .push_data (q_in),
    .pop       (pop_evt),
    .flush     (disable_evt),
    .head      (q_head),
    .valid     (q_valid),
    .full      (q_full)
  );

  dmaq_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (pop_evt),
    .end_evt    (done_strobe),
    .mask_we    (wr_mask),
    .mask_wdata (reg_wdata[1:0]),
    .clr_we     (wr_pend),
    .clr_bits   (reg_wdata[1:0]),
    .pend       (irq_pend),
    .mask       (irq_mask),
    .src        (irq_src),
    .irq        (irq)
  );

  dmaq_idtrack u_ids (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc       (push_evt),
    .start_evt   (handoff_evt),
    .start_id    (q_head.id),
    .done_strobe (done_strobe),
    .done_id     (done_id),
    .next_id     (next_id),
    .done_map    (done_map),
    .active_id   (active_id)
  );

  assign req_id     = q_head.id;
  assign req_cyclic = q_head.cyclic;
  assign req_dst    = q_head.dst;
  assign req_src    = q_head.src;
  assign req_len    = q_head.len;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_AW'(OFS_IRQ_MASK): reg_rdata = DATA_W'(irq_mask);
      REG_AW'(OFS_IRQ_PEND): reg_rdata = DATA_W'(irq_pend);
      REG_AW'(OFS_IRQ_SRC):  reg_rdata = DATA_W'(irq_src);
      REG_AW'(OFS_CTRL):     reg_rdata = DATA_W'({ctrl_pause, ctrl_en});
      REG_AW'(OFS_NEXT_ID):  reg_rdata = DATA_W'(next_id);
      REG_AW'(OFS_SUBMIT):   reg_rdata = DATA_W'(busy);
      REG_AW'(OFS_FLAGS):    reg_rdata = DATA_W'(stg_cyc);
      REG_AW'(OFS_DST):      reg_rdata = DATA_W'(stg_dst);
      REG_AW'(OFS_SRC):      reg_rdata = DATA_W'(stg_src);
      REG_AW'(OFS_LEN):      reg_rdata = DATA_W'(stg_len);
      REG_AW'(OFS_DONE):     reg_rdata = DATA_W'(done_map);
      REG_AW'(OFS_ACTIVE):   reg_rdata = DATA_W'(active_id);
      default:               reg_rdata = '0;
    endcase
  end

  // R4: an offered request holds until taken
  a_r4_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack && !wr_ctrl) |=>
      (req_valid && $stable(req_id) && $stable(req_len)));
  // R10: a repeating request is offered again with the same tag
  a_r10_repeat_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (handoff_evt && req_cyclic && !wr_ctrl) |=>
      (req_valid && req_id == $past(req_id)));
  // R9: disabling drops all queued and pending work
  a_r9_disable_empties: assert property (@(posedge clk) disable iff (!rst_n)
    disable_evt |=> (!req_valid && !busy));
endmodule

// File: tb/dma_req_frontend_test.sv
`timescale 1ns/1ps
module dma_req_frontend_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_cyclic, irq;
  logic [4:0]  req_id;
  logic [31:0] req_dst, req_src;
  logic [23:0] req_len;
  logic        req_ack = 1'b0;
  logic        done_strobe = 1'b0;
  logic [4:0]  done_id = '0;

  always #2.5 clk = ~clk;

  dma_req_frontend uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_id(req_id), .req_cyclic(req_cyclic), .req_dst(req_dst),
    .req_src(req_src), .req_len(req_len), .req_ack(req_ack),
    .done_strobe(done_strobe), .done_id(done_id), .irq(irq)
  );

  typedef struct {
    logic [4:0]  id;
    logic        cyc;
    logic [31:0] dst;
    logic [31:0] src;
    logic [23:0] len;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0, n_bad = 0, n_handoff = 0;
  bit   ack_en = 0, cyc_mode = 0, finished = 0;
  logic [4:0] mdl_id = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  // driver: stage, submit, record expectation
  task automatic submit(input bit cyc, input bit wait_free);
    logic [31:0] v;
    exp_t e;
    if (wait_free) begin
      rd(12'h408, v);
      while (v != 0) begin @(negedge clk); rd(12'h408, v); end
    end
    e.id  = mdl_id;
    e.cyc = cyc;
    e.dst = 32'h8000_0000 + {mdl_id, 8'h00};
    e.src = 32'h0040_0000 + {mdl_id, 4'h4};
    e.len = 24'h100 + {19'd0, mdl_id};
    wr(12'h40c, {31'd0, cyc});
    wr(12'h410, e.dst);
    wr(12'h414, e.src);
    wr(12'h418, {8'd0, e.len});
    wr(12'h408, 32'd1);
    exp_q.push_back(e);
    mdl_id = mdl_id + 5'd1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare each taken request with the scoreboard
  always @(negedge clk) begin
    exp_t e;
    req_ack = 1'b0;
    if (rst_n && ack_en && req_valid) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected request", {27'd0, req_id}, 32'hffff_ffff);
      end else begin
        e = cyc_mode ? exp_q[0] : exp_q.pop_front();
        chk("R4 order tag",      {27'd0, req_id}, {27'd0, e.id});
        chk("R2 payload dst",    req_dst, e.dst);
        chk("R2 payload src",    req_src, e.src);
        chk("R2 payload len",    {8'd0, req_len}, {8'd0, e.len});
        chk("R10 repeat flag",   {31'd0, req_cyclic}, {31'd0, e.cyc});
      end
      n_handoff++;
      req_ack = 1'b1;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    int h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rchk("R1 mask",     12'h080, 32'd3);
    rchk("R1 pending",  12'h084, 32'd0);
    rchk("R1 ctrl",     12'h400, 32'd0);
    rchk("R1 next tag", 12'h404, 32'd0);
    rchk("R1 submit",   12'h408, 32'd0);
    rchk("R1 bitmap",   12'h428, 32'd0);
    rchk("R1 active",   12'h42c, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 req_valid", {31'd0, req_valid}, 32'd0);

    wr(12'h080, 32'd0);
    wr(12'h400, 32'd1);

    // fill the queue without taking anything
    submit(0, 1);
    rchk("R3 busy while pending", 12'h408, 32'd1);
    @(negedge clk);
    rchk("R2 tag advances", 12'h404, 32'd1);
    rchk("R3 free after push", 12'h408, 32'd0);
    submit(0, 1); submit(0, 1); submit(0, 1);
    repeat (2) @(negedge clk);
    rchk("R3 busy when full", 12'h408, 32'd1);
    submit(0, 0);                       // fifth, waits for room
    repeat (3) @(negedge clk);
    rchk("R3 still busy", 12'h408, 32'd1);
    rchk("R2 no tag while full", 12'h404, 32'd4);
    chk("R4 head is first", {27'd0, req_id}, 32'd0);
    rchk("R4 no start event yet", 12'h084, 32'd0);
    ack_en = 1;
    drain();
    rchk("R2 tag after drain", 12'h404, 32'd5);
    rchk("R4 start event", 12'h084, 32'd1);
    chk("R7 irq on start", {31'd0, irq}, 32'd1);
    wr(12'h084, 32'd1);
    rchk("R6 cleared", 12'h084, 32'd0);
    chk("R7 irq low", {31'd0, irq}, 32'd0);

    // completion strobe
    @(negedge clk); done_strobe = 1'b1; done_id = 5'd2;
    @(negedge clk); done_strobe = 1'b0;
    rchk("R5 bitmap bit 2", 12'h428, 32'h4);
    rchk("R5 end event", 12'h084, 32'd2);
    chk("R7 irq on end", {31'd0, irq}, 32'd1);
    wr(12'h080, 32'd2);
    rchk("R7 source masked", 12'h088, 32'd0);
    chk("R7 irq masked", {31'd0, irq}, 32'd0);
    wr(12'h080, 32'd0);
    rchk("R7 source open", 12'h088, 32'd2);

    // clear and event on the same edge
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h084; reg_wdata = 32'd2;
    done_strobe = 1'b1; done_id = 5'd7;
    @(negedge clk);
    reg_wr = 1'b0; done_strobe = 1'b0;
    rchk("R6 event wins", 12'h084, 32'd2);
    rchk("R5 bitmap bits 2,7", 12'h428, 32'h84);
    wr(12'h084, 32'd3);
    rchk("R6 all cleared", 12'h084, 32'd0);

    // run tags 5..31 then wrap
    for (int i = 0; i < 27; i++) submit(0, 1);
    drain();
    rchk("R12 tag wraps to 0", 12'h404, 32'd0);
    rchk("R5 tag 7 reuse cleared", 12'h428, 32'h4);
    submit(0, 1); submit(0, 1); submit(0, 1);
    drain();
    rchk("R5 tag 2 reuse cleared", 12'h428, 32'd0);
    rchk("R11 active tag", 12'h42c, 32'd2);

    // pause
    wr(12'h400, 32'd3);
    submit(0, 1);
    repeat (2) @(negedge clk);
    chk("R8 paused no offer", {31'd0, req_valid}, 32'd0);
    rchk("R8 submit accepted", 12'h404, 32'd4);
    wr(12'h400, 32'd1);
    drain();
    rchk("R11 active after resume", 12'h42c, 32'd3);

    // disable
    ack_en = 0;
    submit(0, 1); submit(0, 1);
    repeat (2) @(negedge clk);
    chk("R9 queued offer", {31'd0, req_valid}, 32'd1);
    wr(12'h400, 32'd0);
    exp_q.delete();
    chk("R9 offer dropped", {31'd0, req_valid}, 32'd0);
    rchk("R9 not busy", 12'h408, 32'd0);
    rchk("R9 tag kept", 12'h404, 32'd6);
    wr(12'h408, 32'd1);
    @(negedge clk);
    rchk("R9 submit ignored", 12'h408, 32'd0);
    rchk("R9 tag unchanged", 12'h404, 32'd6);
    wr(12'h400, 32'd1);
    repeat (2) @(negedge clk);
    chk("R9 queue empty", {31'd0, req_valid}, 32'd0);

    // repeating request
    wr(12'h084, 32'd3);
    cyc_mode = 1;
    ack_en = 1;
    h0 = n_handoff;
    submit(1, 1);
    submit(0, 1);
    repeat (6) @(negedge clk);
    ack_en = 0;
    @(negedge clk);
    chk("R10 repeated takes", {31'd0, (n_handoff - h0) >= 3}, 32'd1);
    chk("R10 still offered", {31'd0, req_valid}, 32'd1);
    chk("R10 same tag", {27'd0, req_id}, 32'd6);
    rchk("R10 no start event", 12'h084, 32'd0);
    rchk("R11 active repeat tag", 12'h42c, 32'd6);
    rchk("R2 both tags issued", 12'h404, 32'd8);
    wr(12'h400, 32'd0);
    exp_q.delete();
    cyc_mode = 0;
    chk("R9 repeat stopped", {31'd0, req_valid}, 32'd0);

    report();
  end
endmodule